// File: doc/BRIEF.md
# Dual-Path Microprogram Sequencer

This block is a small microprogrammed control unit. A 4-bit address register selects one of eleven 14-bit microwords held in a fixed on-chip table. Each word drives six micro-operation lines and a stop line. It also tells the sequencer how to form the next address. Two next-address routes exist, and a one-bit route flag in each word picks between them.

With the flag clear, the word names a single condition input or an unconditional transfer. The next address is either the current address plus one or the word's own false-target field. With the flag set, the condition selector and the false-target field have no effect. A fixed sum-of-products function of the current address and six condition inputs then supplies the whole next address.

A start pulse enters the program at address 0000. The program ends at one of two terminating words, which raise the stop line for one cycle and jump back to 0000. The sequencer then idles until the next start.

Top module: `dual_path_useq`

## Requirements
- R1: During and after reset, with no start seen, the sequencer is idle: `yOut` is 0, `stopOut` is 0 and `uAddr` is 0000.
- R2: A start pulse sampled at a clock edge loads address 0000 and sets the sequencer running. While it is running, the address register changes once on every following edge.
- R3: A word with the route flag clear and selector 01 tests x7 (`condIn[6]`); selector 10 tests x3 (`condIn[2]`). If the tested bit is 1, the next address is the current address plus one. If it is 0, the next address is the word's false target. The words are 0001 (tests x7, false target 0001) and 0100 (tests x3, false target 1001).
- R4: A word with the route flag clear and selector 00 always moves to its false target, whatever the condition inputs are. The transfers are 0000→0110, 0011→0000, 0101→0100, 0111→1001, 1000→1001 and 1010→0000.
- R5: The words at 0010, 0110 and 1001 have the route flag set. For these words the next address depends only on the address and x1..x6 (`condIn[0]..condIn[5]`), as follows. At 0110: x1·x2→0001; x1·!x2→0111; !x1·x3→1000; !x1·!x3·x4→1001; otherwise→0100. At 0010: x5→0011; !x5·x6→1010; otherwise→0011. At 1001: x5→1010; !x5·x6→0011; otherwise→0100.
- R6: While running, `yOut` bit k carries micro-operation y(k+1) of the current word. The values for addresses 0000..1010 are 000000, 011000, 100010, 000111, 001100, 100010, 000110, 001100, 010010, 001000 and 000101, written as bits 5..0.
- R7: `stopOut` is 1 only while running at address 0011 or 1010. The following edge returns the address to 0000 and leaves the sequencer idle. While idle, the address holds, `yOut` is 0 and `stopOut` is 0, whatever the condition inputs are.
- R8: A start pulse that arrives while the sequencer is running restarts it at address 0000 on that edge, and it keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start strobe: enter the program at address 0000 |
| condIn | input | 7 | Logical conditions; bit i is x(i+1) |
| yOut | output | 6 | Micro-operation lines y1..y6 (bit 0 is y1) |
| stopOut | output | 1 | Program-finished indication |
| uAddr | output | 4 | Current microprogram address |

## Verification
The embedded properties check four rules on every clock. A start always lands on 0000. A conditional word that sees its tested bit set moves to the next consecutive address. An unconditional word lands on its false target. An idle sequencer keeps its address and stays silent, and a stop word always ends the run. Whether the sum-of-products branch function picks the right target for every mix of x1..x6, and whether each address carries the right micro-operation pattern, can only be shown by the bench. It steps an independent state-table model beside the design through directed walks and randomized condition streams.

// File: rtl/dpu_pkg.sv
`timescale 1ns/1ps
package dpu_pkg;
  localparam int ADDR_W    = 4;
  localparam int COND_W    = 7;
  localparam int Y_W       = 6;
  localparam int SEL_W     = 2;
  localparam int BR_COND_W = 6;
  localparam int X7_IDX    = 6;
  localparam int X3_IDX    = 2;
  localparam int WORD_W    = 1 + 1 + Y_W + SEL_W + ADDR_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_ALWAYS = 2'b00,
    SEL_X7     = 2'b01,
    SEL_X3     = 2'b10,
    SEL_SPARE  = 2'b11
  } sel_e;

  typedef struct packed {
    logic              multiPath;
    logic              stopBit;
    logic [Y_W-1:0]    yBits;
    sel_e              sel;
    logic [ADDR_W-1:0] falseAddr;
  } uword_t;

  typedef struct packed {
    logic restart;
    logic step;
  } strobe_t;

  function automatic uword_t mkWord(input logic multi, input logic stop,
                                    input logic [Y_W-1:0] y,
                                    input logic [SEL_W-1:0] sel,
                                    input logic [ADDR_W-1:0] fa);
    uword_t w;
    w.multiPath = multi;
    w.stopBit   = stop;
    w.yBits     = y;
    w.sel       = sel_e'(sel);
    w.falseAddr = fa;
    return w;
  endfunction
endpackage

// File: rtl/dpu_rom.sv
`timescale 1ns/1ps
module dpu_rom
  import dpu_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  always_comb begin
    case (addr)
      4'b0000: word = mkWord(1'b0, 1'b0, 6'b000000, 2'b00, 4'b0110);
      4'b0001: word = mkWord(1'b0, 1'b0, 6'b011000, 2'b01, 4'b0001);
      4'b0010: word = mkWord(1'b1, 1'b0, 6'b100010, 2'b00, 4'b0000);
      4'b0011: word = mkWord(1'b0, 1'b1, 6'b000111, 2'b00, 4'b0000);
      4'b0100: word = mkWord(1'b0, 1'b0, 6'b001100, 2'b10, 4'b1001);
      4'b0101: word = mkWord(1'b0, 1'b0, 6'b100010, 2'b00, 4'b0100);
      4'b0110: word = mkWord(1'b1, 1'b0, 6'b000110, 2'b00, 4'b0000);
      4'b0111: word = mkWord(1'b0, 1'b0, 6'b001100, 2'b00, 4'b1001);
      4'b1000: word = mkWord(1'b0, 1'b0, 6'b010010, 2'b00, 4'b1001);
      4'b1001: word = mkWord(1'b1, 1'b0, 6'b001000, 2'b00, 4'b0000);
      4'b1010: word = mkWord(1'b0, 1'b1, 6'b000101, 2'b00, 4'b0000);
      default: word = mkWord(1'b0, 1'b0, 6'b000000, 2'b00, 4'b0000);
    endcase
  end
endmodule

// File: rtl/dpu_branch.sv
`timescale 1ns/1ps
module dpu_branch
  import dpu_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BR_COND_W-1:0] cond,
  output logic [ADDR_W-1:0]    branchAddr
);
  logic x1, x2, x3, x4, x5, x6;
  logic atA2, atA7, atA8;

  assign {x6, x5, x4, x3, x2, x1} = cond;
  assign atA2 = (addr == 4'b0110);
  assign atA7 = (addr == 4'b0010);
  assign atA8 = (addr == 4'b1001);

  // Sum-of-products: each product term ORs its target code into the result
  always_comb begin
    branchAddr = '0;
    if (atA2 &&  x1 &&  x2)              branchAddr = branchAddr | 4'b0001;
    if (atA2 &&  x1 && !x2)              branchAddr = branchAddr | 4'b0111;
    if (atA2 && !x1 &&  x3)              branchAddr = branchAddr | 4'b1000;
    if (atA2 && !x1 && !x3 &&  x4)       branchAddr = branchAddr | 4'b1001;
    if (atA2 && !x1 && !x3 && !x4)       branchAddr = branchAddr | 4'b0100;
    if (atA7 &&  x5)                     branchAddr = branchAddr | 4'b0011;
    if (atA7 && !x5 &&  x6)              branchAddr = branchAddr | 4'b1010;
    if (atA7 && !x5 && !x6)              branchAddr = branchAddr | 4'b0011;
    if (atA8 &&  x5)                     branchAddr = branchAddr | 4'b1010;
    if (atA8 && !x5 &&  x6)              branchAddr = branchAddr | 4'b0011;
    if (atA8 && !x5 && !x6)              branchAddr = branchAddr | 4'b0100;
  end
endmodule

// File: rtl/dpu_datapath.sv
`timescale 1ns/1ps
module dpu_datapath
  import dpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [COND_W-1:0] cond,
  output logic [ADDR_W-1:0] addrQ,
  output uword_t            word
);
  logic              testBit;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] branchAddr;
  logic [ADDR_W-1:0] nextAddr;

  dpu_rom romI (.addr(addrQ), .word(word));

  dpu_branch branchI (
    .addr(addrQ),
    .cond(cond[BR_COND_W-1:0]),
    .branchAddr(branchAddr)
  );

  always_comb begin
    case (word.sel)
      SEL_X7:  testBit = cond[X7_IDX];
      SEL_X3:  testBit = cond[X3_IDX];
      default: testBit = 1'b0;
    endcase
  end

  assign seqAddr  = testBit ? addrQ + ADDR_W'(1) : word.falseAddr;
  assign nextAddr = word.multiPath ? branchAddr : seqAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrQ <= '0;
    else if (strobe.restart) addrQ <= '0;
    else if (strobe.step)    addrQ <= nextAddr;
  end

  // R2
  restart_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> addrQ == '0);

  // R3
  cond_true_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.restart && !word.multiPath &&
     ((word.sel == SEL_X7 && cond[X7_IDX]) || (word.sel == SEL_X3 && cond[X3_IDX])))
    |=> addrQ == $past(addrQ) + ADDR_W'(1));

  // R4
  uncond_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.restart && !word.multiPath && word.sel == SEL_ALWAYS)
    |=> addrQ == $past(word.falseAddr));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !strobe.step) |=> $stable(addrQ));
endmodule

// File: rtl/dpu_ctrl.sv
`timescale 1ns/1ps
module dpu_ctrl
  import dpu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    stopBit,
  output strobe_t strobe,
  output logic    running
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   running <= 1'b0;
    else if (startIn)            running <= 1'b1;
    else if (running && stopBit) running <= 1'b0;
  end

  assign strobe.restart = startIn;
  assign strobe.step    = running && !startIn;

  // R7
  stop_goes_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && stopBit && !startIn) |=> !running);

  // R8
  start_runs_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> running);
endmodule

// File: rtl/dual_path_useq.sv
`timescale 1ns/1ps
module dual_path_useq
  import dpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [COND_W-1:0] condIn,
  output logic [Y_W-1:0]    yOut,
  output logic              stopOut,
  output logic [ADDR_W-1:0] uAddr
);
  strobe_t strobe;
  logic    running;
  uword_t  word;

  dpu_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .stopBit(word.stopBit), .strobe(strobe), .running(running)
  );

  dpu_datapath dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cond(condIn),
    .addrQ(uAddr), .word(word)
  );

  assign yOut    = running ? word.yBits : '0;
  assign stopOut = running && word.stopBit;

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (yOut == '0 && !stopOut));
endmodule

// File: tb/dual_path_useq_tb_top.sv
`timescale 1ns/1ps
module dual_path_useq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [6:0] condIn = '0;
  logic [5:0] yOut;
  logic       stopOut;
  logic [3:0] uAddr;

  int  vecCnt = 0;
  int  failCnt = 0;
  bit  finished = 0;

  logic [3:0] refAddr = '0;
  logic       refRun  = 1'b0;

  always #2.5 clk = ~clk;

  dual_path_useq dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .condIn(condIn),
    .yOut(yOut), .stopOut(stopOut), .uAddr(uAddr)
  );

  function automatic logic [5:0] refY(input logic [3:0] a);
    case (a)
      4'd0:  return 6'b000000;
      4'd1:  return 6'b011000;
      4'd2:  return 6'b100010;
      4'd3:  return 6'b000111;
      4'd4:  return 6'b001100;
      4'd5:  return 6'b100010;
      4'd6:  return 6'b000110;
      4'd7:  return 6'b001100;
      4'd8:  return 6'b010010;
      4'd9:  return 6'b001000;
      4'd10: return 6'b000101;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic refZ(input logic [3:0] a);
    return (a == 4'd3) || (a == 4'd10);
  endfunction

  function automatic logic [3:0] refNext(input logic [3:0] a, input logic [6:0] c);
    case (a)
      4'd0:  return 4'd6;
      4'd1:  return c[6] ? 4'd2 : 4'd1;
      4'd2:  return c[4] ? 4'd3 : (c[5] ? 4'd10 : 4'd3);
      4'd3:  return 4'd0;
      4'd4:  return c[2] ? 4'd5 : 4'd9;
      4'd5:  return 4'd4;
      4'd6:  return (c[0] && c[1]) ? 4'd1 : c[0] ? 4'd7 : c[2] ? 4'd8 : c[3] ? 4'd9 : 4'd4;
      4'd7:  return 4'd9;
      4'd8:  return 4'd9;
      4'd9:  return c[4] ? 4'd10 : (c[5] ? 4'd3 : 4'd4);
      4'd10: return 4'd0;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string addrTag(input logic [3:0] a);
    if (a == 4'd2 || a == 4'd6 || a == 4'd9) return "R5";
    if (a == 4'd1 || a == 4'd4) return "R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h (time %0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(input string addrTagStr);
    check(addrTagStr, "uAddr", int'(uAddr), int'(refAddr));
    check("R6", "yOut", int'(yOut), refRun ? int'(refY(refAddr)) : 0);
    check("R7", "stopOut", int'(stopOut), int'(refRun && refZ(refAddr)));
  endtask

  // Called at a falling edge: drive, advance model, sample at next falling edge
  task automatic stepCycle(input logic st, input logic [6:0] c);
    string      tag;
    logic [3:0] nA;
    logic       nR;
    startIn = st;
    condIn  = c;
    if (st) begin
      tag = refRun ? "R8" : "R2";
      nA = 4'd0; nR = 1'b1;
    end else if (refRun) begin
      tag = addrTag(refAddr);
      nA = refNext(refAddr, c);
      nR = !refZ(refAddr);
    end else begin
      tag = "R7";
      nA = refAddr; nR = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    refAddr = nA;
    refRun  = nR;
    checkOutputs(tag);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkOutputs("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkOutputs("R1");
    stepCycle(1'b0, 7'h7f);
    check("R1", "uAddr idle", int'(uAddr), 0);
  endtask

  task automatic testWalkConditional();
    stepCycle(1'b1, 7'h00);               // R2 enter at 0000
    check("R2", "entry", int'(uAddr), 0);
    stepCycle(1'b0, 7'h00);               // R4 0000 -> 0110
    stepCycle(1'b0, 7'b0000011);          // R5 x1 x2 -> 0001
    check("R5", "a2 to 0001", int'(uAddr), 1);
    stepCycle(1'b0, 7'b0111111);          // R3 x7=0 stays
    check("R3", "x7 low holds", int'(uAddr), 1);
    stepCycle(1'b0, 7'b1000000);          // R3 x7=1 increments
    check("R3", "x7 high incr", int'(uAddr), 2);
    stepCycle(1'b0, 7'b0100000);          // R5 !x5 x6 -> 1010
    check("R5", "a7 to 1010", int'(uAddr), 10);
    check("R7", "stop at 1010", int'(stopOut), 1);
    stepCycle(1'b0, 7'h7f);               // R7 back to 0000, idle
    check("R7", "idle after stop", int'(uAddr), 0);
    check("R7", "quiet y", int'(yOut), 0);
  endtask

  task automatic testWalkUncond();
    stepCycle(1'b1, 7'h7f);
    stepCycle(1'b0, 7'h7f);               // R4 ignores conditions
    check("R4", "0000 to 0110", int'(uAddr), 6);
    stepCycle(1'b0, 7'b1110000);          // R5 !x1 !x3 !x4 -> 0100
    check("R5", "a2 to 0100", int'(uAddr), 4);
    stepCycle(1'b0, 7'b0000100);          // R3 x3=1 -> 0101
    check("R3", "x3 high incr", int'(uAddr), 5);
    stepCycle(1'b0, 7'h00);               // R4 0101 -> 0100
    check("R4", "0101 to 0100", int'(uAddr), 4);
    stepCycle(1'b0, 7'b1111011);          // R3 x3=0 -> 1001
    check("R3", "x3 low false", int'(uAddr), 9);
    stepCycle(1'b0, 7'b0000000);          // R5 1001 -> 0100
    check("R5", "a8 to 0100", int'(uAddr), 4);
    stepCycle(1'b0, 7'h00);
    stepCycle(1'b0, 7'b0100000);          // R5 !x5 x6 -> 0011
    check("R5", "a8 to 0011", int'(uAddr), 3);
    check("R7", "stop at 0011", int'(stopOut), 1);
    stepCycle(1'b0, 7'h00);
  endtask

  task automatic testIdleHold();
    for (int i = 0; i < 6; i++) stepCycle(1'b0, 7'($urandom));
    check("R7", "hold while idle", int'(uAddr), 0);
  endtask

  task automatic drainRun();
    for (int g = 0; g < 300 && refRun; g++) stepCycle(1'b0, 7'($urandom));
  endtask

  task automatic testRestart();
    stepCycle(1'b1, 7'h00);
    stepCycle(1'b0, 7'h00);
    stepCycle(1'b0, 7'b0000001);          // x1 !x2 -> 0111
    stepCycle(1'b1, 7'h7f);               // R8 restart mid-run
    check("R8", "restart addr", int'(uAddr), 0);
    stepCycle(1'b0, 7'h00);
    check("R8", "keeps running", int'(uAddr), 6);
    drainRun();
  endtask

  task automatic testRandomRuns();
    for (int r = 0; r < 150; r++) begin
      stepCycle(1'b1, 7'($urandom));
      drainRun();
      stepCycle(1'b0, 7'($urandom));
    end
  endtask

  initial begin
    testReset();
    testWalkConditional();
    testWalkUncond();
    testIdleHold();
    testRestart();
    testRandomRuns();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end
endmodule